// File: doc/BRIEF.md
# Daisy-Chain Scan Sequencer

This controller runs a scan test session over several wrapped cores whose internal scan chains sit one after another in a single serial path. Each core's wrapper has a one-bit bypass flop and a 2-to-1 selector. The selector routes the serial path either through the core's chain or through the bypass flop. The controller emits the shift enable, a one-clock capture strobe and one bypass select per core. It works out how many shift cycles each phase needs from per-core chain lengths and pattern counts. Those values are latched when a session starts.

Unloading and loading overlap. While the response of pattern k-1 leaves the path, pattern k enters it. After the last pattern, one final unload-only phase follows. At the start every core is in the path and all cores are tested together. Once a core has had all its patterns and its last response has been unloaded, its bypass is selected. From then on the path is shorter, and the cores that still need patterns keep being tested without a pause.

Top module: `scan_chain_sequencer`

## Requirements
- R1: While reset is asserted, and after it is released, `shiftEn`, `captureEn` and `done` are low and every `bypassSel` bit is 0.
- R2: A `start` pulse seen while the block is idle or done latches `chainLen` and `patCount`. Core i's length is `chainLen[i*LENW +: LENW]` and its count is `patCount[i*PCW +: PCW]`; both must be at least 1. In the next cycle `shiftEn` is high and no bypass is selected.
- R3: A session has phases k = 0..P, where P is the largest latched pattern count. Phase k shifts for exactly the sum of the chain lengths of cores with k <= count, plus one cycle for each core with k > count.
- R4: The `bypassSel[i]` bit is 1 exactly in the phases k > count of core i. It stays 1 until the next session starts.
- R5: Each shift phase k < P is followed by exactly one cycle with `captureEn` high and `shiftEn` low. The next phase begins in the cycle after.
- R6: After the last phase (k = P), `done` rises with no capture cycle before it. `done` stays high, with `shiftEn` and `captureEn` low, until the next start. A session lasts the sum of all phase lengths plus P cycles.
- R7: While a session runs, `start` pulses and changes on `chainLen` or `patCount` have no effect on its timing.
- R8: A `start` pulse while `done` is high begins a new session in the next cycle and clears `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a session when idle or done |
| chainLen | input | NCORES*LENW | Per-core scan chain length, core i at bits i*LENW |
| patCount | input | NCORES*PCW | Per-core pattern count, core i at bits i*PCW |
| shiftEn | output | 1 | Serial path shifts this cycle |
| captureEn | output | 1 | One-clock capture strobe after a loading phase |
| bypassSel | output | NCORES | Per-core selector: 1 routes the path through the bypass flop |
| done | output | 1 | Session complete |

## Verification
Several properties are checked on every cycle:
- the shift counter never reaches the current path length;
- a bypass select, once set, never clears except at a new start;
- every capture sits between two shift cycles;
- `done` holds until a start arrives, and a start during shifting is ignored.

Other behaviour can only be shown by the bench's scenarios. These are the exact length of each phase, the phase in which each core drops into bypass, the total session length, and the fact that changed configuration inputs mid-session leave timing untouched. For these, the bench computes the expected values from the latched lengths and counts.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_CAPT  = 2'd2,
    ST_FIN   = 2'd3
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // latch configuration, clear counters
    logic shiftStep;  // one shift cycle taken
    logic phaseStep;  // advance to next phase
  } seqStrobe_t;

endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       lastShift,
  input  logic       lastPhase,
  output seqStrobe_t strobe,
  output logic       shiftEn,
  output logic       captureEn,
  output logic       done
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE, ST_FIN: begin
        if (start) begin
          strobe.load = 1'b1;
          nextState   = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        strobe.shiftStep = 1'b1;
        if (lastShift) nextState = lastPhase ? ST_FIN : ST_CAPT;
      end
      ST_CAPT: begin
        strobe.phaseStep = 1'b1;
        nextState        = ST_SHIFT;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign shiftEn   = (state == ST_SHIFT);
  assign captureEn = (state == ST_CAPT);
  assign done      = (state == ST_FIN);

  // R5
  capture_then_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    captureEn |=> shiftEn);

  // R5
  capture_after_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    captureEn |-> $past(shiftEn));

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEn && !lastShift) |=> shiftEn);

endmodule

// File: rtl/scan_seq_path.sv
module scan_seq_path
  import scan_seq_pkg::*;
#(
  parameter int NCORES = 3,
  parameter int LENW   = 8,
  parameter int PCW    = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobe_t             strobe,
  input  logic [NCORES*LENW-1:0] chainLen,
  input  logic [NCORES*PCW-1:0]  patCount,
  output logic                   lastShift,
  output logic                   lastPhase,
  output logic [NCORES-1:0]      bypassSel
);

  localparam int SUMW = LENW + $clog2(NCORES + 1);

  logic [LENW-1:0] lenReg [NCORES];
  logic [PCW-1:0]  pcReg  [NCORES];
  logic [PCW-1:0]  phase;
  logic [PCW-1:0]  maxPc;
  logic [SUMW-1:0] shiftCnt;
  logic [SUMW-1:0] pathLen;

  for (genvar g = 0; g < NCORES; g++) begin : gCore
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lenReg[g] <= '0;
        pcReg[g]  <= '0;
      end else if (strobe.load) begin
        lenReg[g] <= chainLen[g*LENW +: LENW];
        pcReg[g]  <= patCount[g*PCW +: PCW];
      end
    end

    // core leaves the path once its last response is unloaded
    assign bypassSel[g] = (phase > pcReg[g]);

    // R4
    bypass_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      (bypassSel[g] && !strobe.load) |=> bypassSel[g]);
  end

  always_comb begin
    pathLen = '0;
    maxPc   = '0;
    for (int i = 0; i < NCORES; i++) begin
      if (bypassSel[i]) pathLen = pathLen + SUMW'(1);
      else              pathLen = pathLen + SUMW'(lenReg[i]);
      if (pcReg[i] > maxPc) maxPc = pcReg[i];
    end
  end

  assign lastShift = (shiftCnt == pathLen - SUMW'(1));
  assign lastPhase = (phase == maxPc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftCnt <= '0;
      phase    <= '0;
    end else if (strobe.load) begin
      shiftCnt <= '0;
      phase    <= '0;
    end else begin
      if (strobe.shiftStep) shiftCnt <= lastShift ? '0 : shiftCnt + SUMW'(1);
      if (strobe.phaseStep) phase <= phase + PCW'(1);
    end
  end

  // R3
  shift_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftStep |-> (shiftCnt < pathLen));

  // R2
  fresh_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (bypassSel == '0));

endmodule

// File: rtl/scan_chain_sequencer.sv
module scan_chain_sequencer
  import scan_seq_pkg::*;
#(
  parameter int NCORES = 3,
  parameter int LENW   = 8,
  parameter int PCW    = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [NCORES*LENW-1:0] chainLen,
  input  logic [NCORES*PCW-1:0]  patCount,
  output logic                   shiftEn,
  output logic                   captureEn,
  output logic [NCORES-1:0]      bypassSel,
  output logic                   done
);

  seqStrobe_t strobe;
  logic       lastShift;
  logic       lastPhase;

  scan_seq_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .lastShift (lastShift),
    .lastPhase (lastPhase),
    .strobe    (strobe),
    .shiftEn   (shiftEn),
    .captureEn (captureEn),
    .done      (done)
  );

  scan_seq_path #(
    .NCORES (NCORES),
    .LENW   (LENW),
    .PCW    (PCW)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .chainLen  (chainLen),
    .patCount  (patCount),
    .lastShift (lastShift),
    .lastPhase (lastPhase),
    .bypassSel (bypassSel)
  );

endmodule

// File: tb/sim_scan_chain_sequencer.sv
`timescale 1ns/1ps
module sim_scan_chain_sequencer;

  localparam int NC = 3;
  localparam int LW = 8;
  localparam int PW = 6;

  typedef struct packed {
    logic [NC*LW-1:0] lens;
    logic [NC*PW-1:0] pcs;
    logic [15:0]      total;
  } caseVec_t;

  // core0 in the low field
  localparam caseVec_t CASES [3] = '{
    '{lens: {8'd3, 8'd6, 8'd4}, pcs: {6'd3, 6'd2, 6'd1}, total: 16'd44},
    '{lens: {8'd2, 8'd2, 8'd2}, pcs: {6'd2, 6'd2, 6'd2}, total: 16'd20},
    '{lens: {8'd2, 8'd5, 8'd1}, pcs: {6'd4, 6'd1, 6'd1}, total: 16'd32}
  };

  logic            clk = 0;
  logic            rstN = 0;
  logic            start = 0;
  logic [NC*LW-1:0] chainLen = '0;
  logic [NC*PW-1:0] patCount = '0;
  logic            shiftEn, captureEn, done;
  logic [NC-1:0]   bypassSel;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  scan_chain_sequencer #(.NCORES(NC), .LENW(LW), .PCW(PW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .chainLen(chainLen),
    .patCount(patCount), .shiftEn(shiftEn), .captureEn(captureEn),
    .bypassSel(bypassSel), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pcOf(input logic [NC*PW-1:0] pcs, input int i);
    return int'(pcs[i*PW +: PW]);
  endfunction

  function automatic int maxPcOf(input logic [NC*PW-1:0] pcs);
    int m = 0;
    for (int i = 0; i < NC; i++) if (pcOf(pcs, i) > m) m = pcOf(pcs, i);
    return m;
  endfunction

  function automatic int expLen(input logic [NC*LW-1:0] lens, input logic [NC*PW-1:0] pcs, input int k);
    int s = 0;
    for (int i = 0; i < NC; i++)
      s += (k <= pcOf(pcs, i)) ? int'(lens[i*LW +: LW]) : 1;
    return s;
  endfunction

  function automatic int expByp(input logic [NC*PW-1:0] pcs, input int k);
    int b = 0;
    for (int i = 0; i < NC; i++) if (k > pcOf(pcs, i)) b |= (1 << i);
    return b;
  endfunction

  task automatic runCase(input caseVec_t cv);
    int p, n, cyc;
    chainLen = cv.lens;
    patCount = cv.pcs;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    // R2 first cycle after start
    check(shiftEn && !done, "R2 shift begins", int'(shiftEn), 1);
    check(bypassSel == '0, "R2 no bypass at start", int'(bypassSel), 0);
    p = maxPcOf(cv.pcs);
    cyc = 0;
    for (int k = 0; k <= p; k++) begin
      n = 0;
      check(int'(bypassSel) == expByp(cv.pcs, k), "R4 bypass per phase",
            int'(bypassSel), expByp(cv.pcs, k));
      while (shiftEn && n < 2000) begin
        n++; cyc++;
        @(negedge clk);
      end
      check(n == expLen(cv.lens, cv.pcs, k), "R3 phase length", n, expLen(cv.lens, cv.pcs, k));
      if (k < p) begin
        check(captureEn && !shiftEn, "R5 capture pulse", int'(captureEn), 1);
        cyc++;
        @(negedge clk);
      end
    end
    check(done && !captureEn, "R6 done after last unload", int'(done), 1);
    check(cyc == int'(cv.total), "R6 session length", cyc, int'(cv.total));
  endtask

  initial begin
    #(8ns * 200000);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!shiftEn && !captureEn && !done && bypassSel == '0, "R1 reset outputs",
          int'({shiftEn, captureEn, done, bypassSel}), 0);
    rstN = 1;
    @(negedge clk);
    check(!shiftEn && !captureEn && !done && bypassSel == '0, "R1 after release",
          int'({shiftEn, captureEn, done, bypassSel}), 0);

    runCase(CASES[0]);
    // R6 hold and R4 sticky bypass after done
    repeat (3) @(negedge clk);
    check(done && !shiftEn && !captureEn, "R6 done held", int'(done), 1);
    check(int'(bypassSel) == expByp(CASES[0].pcs, 3), "R4 bypass held", int'(bypassSel),
          expByp(CASES[0].pcs, 3));

    // R8 restart from done, twice
    runCase(CASES[1]);
    runCase(CASES[2]);

    // R7 start and config changes ignored mid-session
    chainLen = CASES[1].lens;
    patCount = CASES[1].pcs;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    cyc = 0;
    while (!done && cyc < 500) begin
      if (cyc == 3) begin
        start = 1;
        chainLen = {8'd7, 8'd7, 8'd7};
        patCount = {6'd5, 6'd5, 6'd5};
      end
      if (cyc == 4) start = 0;
      cyc++;
      @(negedge clk);
    end
    check(cyc == 20, "R7 mid-session start ignored", cyc, 20);

    // R1 reset in the middle of a session
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    repeat (4) @(negedge clk);
    rstN = 0;
    @(negedge clk);
    check(!shiftEn && !captureEn && !done && bypassSel == '0, "R1 mid-run reset",
          int'({shiftEn, captureEn, done, bypassSel}), 0);
    rstN = 1;
    @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule